// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Port

This block moves stereo audio between parallel sample words and a pair of serial data lines. It runs as a slave in the bit-clock domain: an external master supplies the bit clock `bclk` and the channel clock `lrclk`. The port follows those clocks to find its place in each frame. On the transmit side it takes a left and a right sample and shifts them out MSB first on `sdata_out`. On the receive side it collects the bits on `sdata_in` into a left and a right word and signals each completed pair with a strobe.

One datapath serves four framing conventions, selected at run time by a 3-bit format code. In all four a slot map turns the frame position into three things: the channel, the bit number within the word, and whether the slot carries data. The conventions differ only in where the first bit of a word falls relative to the frame edge. A 2-bit width code selects 24, 20 or 16 data bits per channel. Right-justified framing needs that width to place its first bit so that the word ends on the last slot of its half-frame. Format and width are meant to be changed only between frames, and the port resynchronises on the next frame edge.

Top module: `ssp_port`

## Requirements
- R1: After reset, `sdata_out` and `rx_valid` stay 0 and the received words stay 0 until the first usable `lrclk` edge. That edge is any level change in the stereo formats and a rising edge in DSP format, seen after at least one clock out of reset. Once synchronised, the port stays synchronised until the next reset.
- R2: I2S format (code 000): the first rising `bclk` edge that sees `lrclk` at its new level is slot 0. The word's MSB sits in slot 1 of its half-frame. `lrclk` low selects the left channel and high selects the right channel.
- R3: Left-justified format (code 001): the MSB sits in slot 0 of each half-frame, and channel selection is as in R2.
- R4: Right-justified format (code 010): the LSB sits in the last slot (SLOT_BITS-1) of each half-frame, so the MSB sits in slot SLOT_BITS minus the word width. Channel selection is as in R2.
- R5: DSP format (code 011): a rising `lrclk` edge is frame slot 0 and does not identify a channel. The left MSB is in frame slot 1, and the right word starts in the slot directly after the left LSB.
- R6: Width code 01 gives MAX_W-4 bits (20), code 10 gives MAX_W-8 bits (16), and codes 00 and 11 give MAX_W bits (24).
- R7: Format codes 100 to 111 behave exactly as I2S.
- R8: Transmit bits change on the falling `bclk` edge, MSB first, with sample bit MAX_W-1 as the MSB. Every slot outside a word is driven 0. Both transmit samples are captured on the rising edge that enters the last slot of a frame and are sent in the following frame.
- R9: Receive bits are sampled on the rising `bclk` edge. Slots outside a word are ignored. Each received word is MSB-aligned in its MAX_W-bit output, and the bits below the word width are 0.
- R10: `rx_valid` is high for exactly one `bclk` period, starting at the rising edge that captures the right-channel LSB. Both received words update on that same edge and at no other time.
- R11: A half-frame is SLOT_BITS slots and a frame is 2*SLOT_BITS slots. Between `lrclk` edges the port counts slots on its own, wrapping at the end of the frame, so the transmitter can present the first bit of a frame before the edge that starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external master |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | Channel clock (stereo formats) or frame-sync pulse (DSP format) |
| fmt_sel | input | 3 | Framing format code |
| width_sel | input | 2 | Word width code |
| tx_left | input | MAX_W | Left sample to transmit |
| tx_right | input | MAX_W | Right sample to transmit |
| sdata_out | output | 1 | Serial transmit data |
| sdata_in | input | 1 | Serial receive data |
| rx_left | output | MAX_W | Last received left word, MSB-aligned |
| rx_right | output | MAX_W | Last received right word, MSB-aligned |
| rx_valid | output | 1 | One-period strobe for a new received pair |

## Verification
The bench builds the port with its defaults, SLOT_BITS of 32 and MAX_W of 24. This makes every width code legal and lets the right-justified offset vary from slot 8 to slot 16. It also means a full-width word in DSP format reaches frame slot 48, so both halves of the frame and both ends of each alignment come within reach. The bench fills every slot that carries no data with ones, so any slot-map error shows up in the received words. It moves between formats with a frame edge of the opposite polarity in between, which exercises resynchronisation from both directions.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [2:0] {
    FMT_I2S = 3'b000,
    FMT_LJ  = 3'b001,
    FMT_RJ  = 3'b010,
    FMT_DSP = 3'b011
  } fmt_e;

  // Meaning of one frame slot: does it carry data, which channel, which bit (0 = MSB)
  typedef struct packed {
    logic       active;
    logic       right;
    logic [7:0] idx;
  } slot_t;

  function automatic fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'b001:  return FMT_LJ;
      3'b010:  return FMT_RJ;
      3'b011:  return FMT_DSP;
      default: return FMT_I2S;
    endcase
  endfunction

  function automatic logic [7:0] word_bits(input logic [1:0] code, input int max_w);
    case (code)
      2'b01:   return 8'(max_w - 4);
      2'b10:   return 8'(max_w - 8);
      default: return 8'(max_w);
    endcase
  endfunction

  // Position in frame -> channel / bit number, per framing convention
  function automatic slot_t map_slot(input fmt_e fmt, input logic [7:0] w_bits,
                                     input logic [15:0] pos_in, input int slot_bits);
    slot_t s;
    int    p;
    int    w;
    int    off;
    int    first;
    s     = '0;
    p     = int'(pos_in);
    w     = int'(w_bits);
    off   = 0;
    first = 1;
    if (fmt == FMT_DSP) begin
      if (p >= 1 && p <= 2 * w) begin
        s.active = 1'b1;
        s.right  = (p > w);
        s.idx    = 8'((p > w) ? (p - 1 - w) : (p - 1));
      end
    end else begin
      s.right = (p >= slot_bits);
      off     = s.right ? (p - slot_bits) : p;
      case (fmt)
        FMT_LJ:  first = 0;
        FMT_RJ:  first = slot_bits - w;
        default: first = 1;
      endcase
      if (off >= first && off < first + w) begin
        s.active = 1'b1;
        s.idx    = 8'(off - first);
      end
    end
    return s;
  endfunction

  // Mask that keeps the top w_bits of a max_w word
  function automatic logic [31:0] keep_mask(input logic [7:0] w_bits, input int max_w);
    logic [31:0] ones;
    ones = (max_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << max_w) - 32'd1);
    return ones & ~(ones >> w_bits);
  endfunction

endpackage

// File: rtl/ssp_frame_trk.sv
module ssp_frame_trk #(
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrclk,
  input  logic             dsp_mode,
  output logic [POS_W-1:0] pos_q,
  output logic [POS_W-1:0] pos_d,
  output logic             edge_now,
  output logic             locked
);
  localparam int FRAME = 2 * SLOT_BITS;

  logic lr_q;
  logic primed;

  always_comb begin
    edge_now = primed && (dsp_mode ? (lrclk && !lr_q) : (lrclk != lr_q));
    if (edge_now)
      pos_d = (dsp_mode || !lrclk) ? '0 : POS_W'(SLOT_BITS);
    else if (pos_q == POS_W'(FRAME - 1))
      pos_d = '0;
    else
      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      primed <= 1'b0;
      locked <= 1'b0;
      pos_q  <= '0;
    end else begin
      lr_q   <= lrclk;
      primed <= 1'b1;
      pos_q  <= pos_d;
      if (edge_now) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int MAX_W     = 24,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic [7:0]       w_bits,
  input  logic [POS_W-1:0] pos_q,
  input  logic             locked,
  input  logic [MAX_W-1:0] tx_left,
  input  logic [MAX_W-1:0] tx_right,
  output logic             load_evt,
  output logic             sdata_out
);
  localparam int FRAME = 2 * SLOT_BITS;
  localparam int IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] hold_l;
  logic [MAX_W-1:0] hold_r;
  logic [POS_W-1:0] nxt_pos;
  slot_t            sl;
  logic [IDX_W-1:0] bpos;
  logic [MAX_W-1:0] word;
  logic             bit_d;

  // Capture on the edge that moves the frame into its last slot
  assign load_evt = locked && (pos_q == POS_W'(FRAME - 2));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (load_evt) begin
      hold_l <= tx_left;
      hold_r <= tx_right;
    end
  end

  // Predict the slot the next rising edge will see
  always_comb begin
    nxt_pos = (pos_q == POS_W'(FRAME - 1)) ? '0 : pos_q + 1'b1;
    sl      = map_slot(fmt, w_bits, 16'(nxt_pos), SLOT_BITS);
    bpos    = IDX_W'(MAX_W - 1 - int'(sl.idx));
    word    = sl.right ? hold_r : hold_l;
    bit_d   = locked && sl.active && word[bpos];
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sdata_out <= 1'b0;
    else        sdata_out <= bit_d;
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int MAX_W     = 24,
  parameter int SLOT_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic [7:0]       w_bits,
  input  logic [POS_W-1:0] slot_pos,
  input  logic             slot_ok,
  input  logic             sdata_in,
  output logic             last_evt,
  output logic [MAX_W-1:0] rx_left,
  output logic [MAX_W-1:0] rx_right,
  output logic             rx_valid
);
  localparam int IDX_W = $clog2(MAX_W);

  logic [MAX_W-1:0] acc_l;
  logic [MAX_W-1:0] acc_r;
  logic [MAX_W-1:0] base;
  logic [MAX_W-1:0] merged;
  logic [MAX_W-1:0] keep;
  slot_t            sl;
  logic [IDX_W-1:0] bpos;
  logic             take;

  always_comb begin
    sl       = map_slot(fmt, w_bits, 16'(slot_pos), SLOT_BITS);
    take     = slot_ok && sl.active;
    bpos     = IDX_W'(MAX_W - 1 - int'(sl.idx));
    base     = (sl.idx == 8'd0) ? '0 : (sl.right ? acc_r : acc_l);
    merged   = base;
    merged[bpos] = sdata_in;
    last_evt = take && sl.right && (int'(sl.idx) == int'(w_bits) - 1);
    keep     = MAX_W'(keep_mask(w_bits, MAX_W));
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (take) begin
        if (sl.right) acc_r <= merged;
        else          acc_l <= merged;
      end
      rx_valid <= last_evt;
      if (last_evt) begin
        rx_left  <= acc_l & keep;
        rx_right <= merged & keep;
      end
    end
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int MAX_W     = 24
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrclk,
  input  logic [2:0]       fmt_sel,
  input  logic [1:0]       width_sel,
  input  logic [MAX_W-1:0] tx_left,
  input  logic [MAX_W-1:0] tx_right,
  output logic             sdata_out,
  input  logic             sdata_in,
  output logic [MAX_W-1:0] rx_left,
  output logic [MAX_W-1:0] rx_right,
  output logic             rx_valid
);
  localparam int POS_W = $clog2(2 * SLOT_BITS);

  fmt_e             fmt;
  logic [7:0]       w_bits;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;
  logic             edge_now;
  logic             locked;
  logic             slot_ok;
  logic             load_evt;
  logic             rx_last;

  assign fmt     = decode_fmt(fmt_sel);
  assign w_bits  = word_bits(width_sel, MAX_W);
  assign slot_ok = locked || edge_now;

  ssp_frame_trk #(.SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) trk_i (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .dsp_mode(fmt == FMT_DSP),
    .pos_q(pos_q), .pos_d(pos_d), .edge_now(edge_now), .locked(locked)
  );

  ssp_tx #(.MAX_W(MAX_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) tx_i (
    .bclk(bclk), .rst_n(rst_n), .fmt(fmt), .w_bits(w_bits), .pos_q(pos_q),
    .locked(locked), .tx_left(tx_left), .tx_right(tx_right),
    .load_evt(load_evt), .sdata_out(sdata_out)
  );

  ssp_rx #(.MAX_W(MAX_W), .SLOT_BITS(SLOT_BITS), .POS_W(POS_W)) rx_i (
    .bclk(bclk), .rst_n(rst_n), .fmt(fmt), .w_bits(w_bits), .slot_pos(pos_d),
    .slot_ok(slot_ok), .sdata_in(sdata_in), .last_evt(rx_last),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk
  import ssp_pkg::*;
#(
  parameter int MAX_W = 24
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             locked,
  input logic             rx_last,
  input logic             load_evt,
  input logic             sdata_out,
  input logic             rx_valid,
  input logic [MAX_W-1:0] rx_left,
  input logic [MAX_W-1:0] rx_right,
  input logic [7:0]       w_bits
);
  logic [MAX_W-1:0] low_bits;
  assign low_bits = ~MAX_W'(keep_mask(w_bits, MAX_W));

  AST_QUIET_UNLOCKED: assert property (@(posedge bclk) disable iff (!rst_n)
    !locked |-> (!sdata_out && !rx_valid && !load_evt)); // R1
  AST_LOCK_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
    locked |=> locked); // R1
  AST_VALID_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10
  AST_VALID_AFTER_LSB: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_last |=> rx_valid); // R10
  AST_VALID_NEEDS_LSB: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |-> $past(rx_last)); // R10
  AST_WORDS_HOLD: assert property (@(posedge bclk) disable iff (!rst_n)
    !rx_last |=> ($stable(rx_left) && $stable(rx_right))); // R10
  AST_LOW_BITS_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |-> (((rx_left | rx_right) & low_bits) == '0)); // R9
endmodule

bind ssp_port ssp_port_chk #(.MAX_W(MAX_W)) chk_i (
  .bclk(bclk), .rst_n(rst_n), .locked(locked), .rx_last(rx_last),
  .load_evt(load_evt), .sdata_out(sdata_out), .rx_valid(rx_valid),
  .rx_left(rx_left), .rx_right(rx_right), .w_bits(w_bits)
);

// File: tb/ssp_port_tb_top.sv
module ssp_port_tb_top;
  localparam int CLK_P = 10;
  localparam int SLOT  = 32;
  localparam int MW    = 24;
  localparam int NV    = 10;

  typedef struct packed {
    logic [2:0]    m;
    logic [1:0]    w;
    logic [MW-1:0] l;
    logic [MW-1:0] r;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    {3'b000, 2'b00, 24'h800001, 24'h7FFFFE},
    {3'b001, 2'b00, 24'hC3A5F0, 24'h0F5A3C},
    {3'b010, 2'b00, 24'h123456, 24'hFEDCBA},
    {3'b010, 2'b10, 24'hA5C300, 24'h5A3C00},
    {3'b011, 2'b01, 24'hF0F0F0, 24'h0F0F0F},
    {3'b000, 2'b10, 24'h8001FF, 24'hFFFF00},
    {3'b001, 2'b01, 24'h9ABCDE, 24'h13579B},
    {3'b110, 2'b11, 24'hB00B1E, 24'h4C0FFE},
    {3'b011, 2'b00, 24'h800000, 24'h000001},
    {3'b010, 2'b01, 24'hE1D2C3, 24'h1A2B3C}
  };

  logic          bclk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lrclk = 1'b0;
  logic [2:0]    fmt_sel = 3'b000;
  logic [1:0]    width_sel = 2'b00;
  logic [MW-1:0] tx_left = '0;
  logic [MW-1:0] tx_right = '0;
  logic          sdata_in = 1'b0;
  logic          sdata_out;
  logic [MW-1:0] rx_left;
  logic [MW-1:0] rx_right;
  logic          rx_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) bclk = ~bclk;

  ssp_port #(.SLOT_BITS(SLOT), .MAX_W(MW)) dut_i (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .fmt_sel(fmt_sel),
    .width_sel(width_sel), .tx_left(tx_left), .tx_right(tx_right),
    .sdata_out(sdata_out), .sdata_in(sdata_in), .rx_left(rx_left),
    .rx_right(rx_right), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  function automatic int ref_width(input logic [1:0] c);
    return (c == 2'b01) ? MW - 4 : (c == 2'b10) ? MW - 8 : MW;
  endfunction

  function automatic string ref_tag(input logic [2:0] m);
    if (m[2]) return "R7 R2";
    case (m[1:0])
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return "R2";
    endcase
  endfunction

  // Where each word starts, then whether slot k falls inside it
  function automatic void ref_slot(input logic [2:0] m, input int w, input int k,
                                   output bit act, output bit rt, output int idx);
    int sl;
    int sr;
    case (m[2] ? 2'b00 : m[1:0])
      2'b01:   begin sl = 0;        sr = SLOT;         end
      2'b10:   begin sl = SLOT - w; sr = 2 * SLOT - w; end
      2'b11:   begin sl = 1;        sr = 1 + w;        end
      default: begin sl = 1;        sr = SLOT + 1;     end
    endcase
    act = 1'b0; rt = 1'b0; idx = 0;
    if (k >= sl && k < sl + w) begin act = 1'b1; idx = k - sl; end
    else if (k >= sr && k < sr + w) begin act = 1'b1; rt = 1'b1; idx = k - sr; end
  endfunction

  task automatic slot_step(input logic lr, input logic d, output logic so, output logic v);
    @(negedge bclk);
    lrclk    = lr;
    sdata_in = d;
    @(posedge bclk);
    #(CLK_P / 4);
    so = sdata_out;
    v  = rx_valid;
  endtask

  task automatic run_frame(input vec_t vc, input bit check);
    int            w;
    logic [MW-1:0] rxl;
    logic [MW-1:0] rxr;
    int            bad_tx;
    int            bad_v;
    w      = ref_width(vc.w);
    rxl    = ~vc.r;
    rxr    = vc.l ^ 24'h5A5A5A;
    bad_tx = 0;
    bad_v  = 0;
    for (int k = 0; k < 2 * SLOT; k++) begin
      bit   act;
      bit   rt;
      int   idx;
      logic lr;
      logic din;
      logic so;
      logic v;
      logic exp_so;
      logic exp_v;
      ref_slot(vc.m, w, k, act, rt, idx);
      lr  = (vc.m == 3'b011) ? (k == 0) : (k >= SLOT);
      din = act ? (rt ? rxr[MW-1-idx] : rxl[MW-1-idx]) : 1'b1; // R9 filler ones
      slot_step(lr, din, so, v);
      exp_so = act ? (rt ? vc.r[MW-1-idx] : vc.l[MW-1-idx]) : 1'b0;
      exp_v  = act && rt && (idx == w - 1);
      if (so !== exp_so) bad_tx++;
      if (v !== exp_v) bad_v++;
    end
    if (check) begin
      chk({ref_tag(vc.m), " R6 R8 R11"}, "tx bit errors", 32'(bad_tx), 32'd0);
      chk({ref_tag(vc.m), " R6 R9"}, "rx_left", 32'(rx_left), 32'(rxl & ~(24'hFFFFFF >> w)));
      chk({ref_tag(vc.m), " R6 R9"}, "rx_right", 32'(rx_right), 32'(rxr & ~(24'hFFFFFF >> w)));
      chk("R10", "rx_valid slot errors", 32'(bad_v), 32'd0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic so;
    logic v;
    tx_left  = 24'hFFFFFF;
    tx_right = 24'hFFFFFF;
    repeat (3) @(posedge bclk);
    @(negedge bclk);
    rst_n = 1'b1;
    // R1: no lrclk edge yet, so the port must stay quiet
    for (int i = 0; i < 6; i++) begin
      slot_step(1'b0, 1'b1, so, v);
      chk("R1", "sdata_out before sync", 32'(so), 32'd0);
    end
    chk("R1", "rx_valid before sync", 32'(v), 32'd0);
    chk("R1", "rx_left after reset", 32'(rx_left), 32'd0);
    chk("R1", "rx_right after reset", 32'(rx_right), 32'd0);

    // Table walk: two frames to resynchronise, then one checked frame
    for (int n = 0; n < NV; n++) begin
      slot_step(lrclk, 1'b0, so, v);
      fmt_sel   = VECS[n].m;
      width_sel = VECS[n].w;
      tx_left   = VECS[n].l;
      tx_right  = VECS[n].r;
      run_frame(VECS[n], 1'b0);
      run_frame(VECS[n], 1'b0);
      run_frame(VECS[n], 1'b1);
    end

    // R1: reset in mid-run clears outputs and desynchronises again
    @(negedge bclk);
    rst_n = 1'b0;
    #(CLK_P / 4);
    chk("R1", "rx_left in reset", 32'(rx_left), 32'd0);
    chk("R1", "rx_valid in reset", 32'(rx_valid), 32'd0);
    @(negedge bclk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      slot_step(lrclk, 1'b1, so, v);
      chk("R1", "sdata_out after re-reset", 32'(so), 32'd0);
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule